// File: doc/BRIEF.md
# Button-Selected Hex Digit Display Driver

This block drives a four-digit seven-segment display of the common-anode type from a 16-bit value. A 2-bit select input chooses one of the four 4-bit fields of the value. The chosen field passes through a hexadecimal decoder that produces the segment pattern for the digits 0 through F.

The digit enable lines do not come from a scan counter. Four push-button inputs drive them directly, so the user lights whichever digit positions are held down. Every path is combinational. There is no clock, no register and no debouncing, so outputs follow the inputs in the same time step.

Top module: `hexdigit_select_display`

## Requirements
- R1: When `sel_i` is 2'b00 the segment outputs show the hex value of `data_i[3:0]`.
- R2: When `sel_i` is 2'b01 the segment outputs show the hex value of `data_i[7:4]`.
- R3: When `sel_i` is 2'b10 the segment outputs show the hex value of `data_i[11:8]`.
- R4: When `sel_i` is 2'b11 the segment outputs show the hex value of `data_i[15:12]`.
- R5: Each anode output `an_n_o[i]` is active-low and equals the inverse of `btn_i[i]`. A pressed button (1) lights digit i, and a released button leaves it dark (1), for every one of the 16 button combinations.
- R6: `seg_n_o` is active-low, with bit 6 as segment a down to bit 0 as segment g. The patterns are:
  - 0 = 0000001, 1 = 1001111, 2 = 0010010, 3 = 0000110
  - 4 = 1001100, 5 = 0100100, 6 = 0100000, 7 = 0001111
  - 8 = 0000000, 9 = 0000100, A = 0001000, b = 1100000
  - C = 0110001, d = 1000010, E = 0110000, F = 0111000
- R7: The segment outputs do not depend on `btn_i` or on the three unselected fields of `data_i`. The anode outputs do not depend on `data_i` or `sel_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 16 | Four hex digits to choose from |
| sel_i | input | 2 | Index of the 4-bit field to decode |
| btn_i | input | 4 | Push-button levels, 1 = pressed |
| seg_n_o | output | 7 | Segments a..g, active-low, a in bit 6 |
| an_n_o | output | 4 | Digit enables, active-low |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench changes inputs at the falling clock edge and samples one nanosecond later, well before the next rising edge. Each sample therefore sees settled combinational values.

The sweep covers all sixteen field values in each of the four select positions and all sixteen button combinations. Separate steps toggle the buttons and the unselected fields while the outputs that must not move are watched.

// File: rtl/hexdigit_select_display.sv
module hexdigit_select_display (
  input  logic [15:0] data_i,
  input  logic [1:0]  sel_i,
  input  logic [3:0]  btn_i,
  output logic [6:0]  seg_n_o,
  output logic [3:0]  an_n_o
);

  logic [3:0] nib;

  // quad 4-to-1 multiplexer
  always @(*) begin
    case (sel_i)
      2'b00:   nib = data_i[3:0];
      2'b01:   nib = data_i[7:4];
      2'b10:   nib = data_i[11:8];
      2'b11:   nib = data_i[15:12];
      default: nib = 4'hx;
    endcase
  end

  // active-low segments {a,b,c,d,e,f,g}
  always @(*) begin
    case (nib)
      4'h0:    seg_n_o = 7'b0000001;
      4'h1:    seg_n_o = 7'b1001111;
      4'h2:    seg_n_o = 7'b0010010;
      4'h3:    seg_n_o = 7'b0000110;
      4'h4:    seg_n_o = 7'b1001100;
      4'h5:    seg_n_o = 7'b0100100;
      4'h6:    seg_n_o = 7'b0100000;
      4'h7:    seg_n_o = 7'b0001111;
      4'h8:    seg_n_o = 7'b0000000;
      4'h9:    seg_n_o = 7'b0000100;
      4'hA:    seg_n_o = 7'b0001000;
      4'hB:    seg_n_o = 7'b1100000;
      4'hC:    seg_n_o = 7'b0110001;
      4'hD:    seg_n_o = 7'b1000010;
      4'hE:    seg_n_o = 7'b0110000;
      4'hF:    seg_n_o = 7'b0111000;
      default: seg_n_o = 7'b1111111;
    endcase
  end

  assign an_n_o = ~btn_i;

endmodule

// File: rtl/hexdigit_select_display_chk.sv
module hexdigit_select_display_chk (
  input logic [15:0] data_i,
  input logic [1:0]  sel_i,
  input logic [3:0]  btn_i,
  input logic [6:0]  seg_n_o,
  input logic [3:0]  an_n_o
);

  function automatic int lit_count(input logic [3:0] v);
    case (v)
      4'h0, 4'h6, 4'h9, 4'hA: return 6;
      4'h1:                   return 2;
      4'h7:                   return 3;
      4'h4, 4'hC, 4'hF:       return 4;
      4'h8:                   return 7;
      default:                return 5;
    endcase
  endfunction

  always_comb begin
    if (sel_i == 2'd0)
      p_field0_lit_r1: assert ($countones(~seg_n_o) == lit_count(data_i[3:0]));
    if (sel_i == 2'd1)
      p_field1_lit_r2: assert ($countones(~seg_n_o) == lit_count(data_i[7:4]));
    if (sel_i == 2'd2)
      p_field2_lit_r3: assert ($countones(~seg_n_o) == lit_count(data_i[11:8]));
    if (sel_i == 2'd3)
      p_field3_lit_r4: assert ($countones(~seg_n_o) == lit_count(data_i[15:12]));
    p_anode_count_r5: assert ($countones(~an_n_o) == $countones(btn_i));
    p_anode_disjoint_r5: assert ((an_n_o & btn_i) == 4'b0000);
    if (((data_i >> (4 * sel_i)) & 16'hF) == 16'h8)
      p_eight_all_on_r6: assert (seg_n_o == 7'b0000000);
    if (((data_i >> (4 * sel_i)) & 16'hF) == 16'h0)
      p_zero_g_off_r6: assert (seg_n_o == 7'b0000001);
  end

endmodule

bind hexdigit_select_display hexdigit_select_display_chk i_chk (
  .data_i(data_i),
  .sel_i(sel_i),
  .btn_i(btn_i),
  .seg_n_o(seg_n_o),
  .an_n_o(an_n_o)
);

// File: tb/test_hexdigit_select_display.sv
`timescale 1ns/1ps
module test_hexdigit_select_display;

  logic        clk = 1'b0;
  logic [15:0] data;
  logic [1:0]  sel;
  logic [3:0]  btn;
  logic [6:0]  seg_n;
  logic [3:0]  an_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hexdigit_select_display i_hexdigit_select_display (
    .data_i(data), .sel_i(sel), .btn_i(btn), .seg_n_o(seg_n), .an_n_o(an_n)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] v);
    case (v)
      4'h0: return 7'b0000001;  4'h1: return 7'b1001111;
      4'h2: return 7'b0010010;  4'h3: return 7'b0000110;
      4'h4: return 7'b1001100;  4'h5: return 7'b0100100;
      4'h6: return 7'b0100000;  4'h7: return 7'b0001111;
      4'h8: return 7'b0000000;  4'h9: return 7'b0000100;
      4'hA: return 7'b0001000;  4'hB: return 7'b1100000;
      4'hC: return 7'b0110001;  4'hD: return 7'b1000010;
      4'hE: return 7'b0110000;  default: return 7'b0111000;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] d, input logic [1:0] s, input logic [3:0] b);
    @(negedge clk);
    data = d; sel = s; btn = b;
    #1;
  endtask

  task automatic t_idle;
    apply(16'h0000, 2'd0, 4'b0000);
    check("R6 idle segments", seg_n, 7'b0000001);
    check("R5 idle anodes", {3'b0, an_n}, 7'b0001111);
  endtask

  task automatic t_sweep(input logic [1:0] s, input string req);
    for (int v = 0; v < 16; v++) begin
      logic [15:0] d;
      d = 16'hFFFF ^ (16'h5A5A + 16'(v * 13));
      d[4*s +: 4] = 4'(v);
      apply(d, s, 4'b0001);
      check({req, " R6 decode"}, seg_n, ref_seg(4'(v)));
    end
  endtask

  task automatic t_buttons;
    for (int b = 0; b < 16; b++) begin
      apply(16'h1234, 2'(b), 4'(b));
      check("R5 anodes", {3'b0, an_n}, {3'b0, ~4'(b)});
    end
  endtask

  task automatic t_isolation;
    apply(16'hABCD, 2'd2, 4'b0100);
    check("R7 base", seg_n, ref_seg(4'hB));
    apply(16'hABCD, 2'd2, 4'b1011);
    check("R7 btn leaves segments", seg_n, ref_seg(4'hB));
    apply(16'h5B21, 2'd2, 4'b1011);
    check("R7 other fields leave segments", seg_n, ref_seg(4'hB));
    check("R7 data leaves anodes", {3'b0, an_n}, 7'b0000100);
    apply(16'h5B21, 2'd0, 4'b1011);
    check("R7 sel leaves anodes", {3'b0, an_n}, 7'b0000100);
    check("R1 after sel change", seg_n, ref_seg(4'h1));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    data = '0; sel = '0; btn = '0;
    t_idle();
    t_sweep(2'd0, "R1");
    t_sweep(2'd1, "R2");
    t_sweep(2'd2, "R3");
    t_sweep(2'd3, "R4");
    t_buttons();
    t_isolation();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule